// File: doc/BRIEF.md
# Machine State Register Update Unit

This unit computes the next value of a 64-bit machine state register for three events: taking a trap, a move-to-register instruction with a partial-update flag, and a return from interrupt. Each cycle the pipeline presents the current register value, a source operand, a saved-state operand, an operation code, the partial flag and a take-trap strobe. One clock later the unit presents the new register value, with a valid flag and a flag that says the next-instruction address must be reloaded.

Bit positions in this document use MSB-0 numbering: bit 0 is the most significant bit. An MSB-0 bit b sits at little-endian index 63-b, so MSB-0 bits 53..54 are port bits [10:9]. Field positions are: IR=58, DR=59, FE0=52, FP=50, UND=56, PMM=61, PR=49, EE=48, RI=62, and the transaction-state field at 29..31. The operation codes on `op_i` are: 2'b00 none, 2'b01 move-to-register, 2'b10 return-from-interrupt, and 2'b11 reserved.

Top module: `msr_update_unit`

## Requirements
- R1: While `rst_ni` is low, `msr_o`, `msr_valid_o` and `nia_valid_o` are all zero.
- R2: When `trap_i` is high, the new value is `msr_i` with IR, DR, FE0, FP, UND, PMM and the two-bit field at 53..54 forced to zero. All other bits are unchanged.
- R3: `trap_i` has priority over every `op_i` code. It sets both `msr_valid_o` and `nia_valid_o`, and the cleared pattern is the same for every trap.
- R4: For a move-to-register with `l_i`=0, new bits 48, 58 and 59 each equal the matching `src_i` bit ORed with `src_i` bit 49.
- R5: For a move-to-register with `l_i`=0, new bits 32..47, 49..50, 52..57 and 60..62 are copied from `src_i`. Bits 0..28, 51 and 63 keep their `msr_i` values.
- R6: For a move-to-register with `l_i`=0, bits 29..31 keep their `msr_i` values when `msr_i` bits 29..31 differ from 3'b010 or `srr_i` bits 29..31 differ from 3'b000. Otherwise they are copied from `src_i`.
- R7: For a move-to-register with `l_i`=1, only bits 48 and 62 are taken from `src_i`. Every other bit keeps its `msr_i` value. The update sets `msr_valid_o` and leaves `nia_valid_o` low.
- R8: A return-from-interrupt loads `srr_i` with bits 48, 58 and 59 each ORed with `srr_i` bit 49. It sets both `msr_valid_o` and `nia_valid_o`.
- R9: With `trap_i` low and `op_i` equal to none or reserved, both valid flags are low in the next cycle and `msr_o` holds its previous value.
- R10: Each result appears on the outputs exactly one clock edge after its inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation code |
| l_i | input | 1 | Partial-update flag for move-to-register |
| trap_i | input | 1 | Take-trap strobe |
| msr_i | input | 64 | Current register value |
| src_i | input | 64 | Source operand |
| srr_i | input | 64 | Saved-state operand |
| msr_o | output | 64 | New register value |
| msr_valid_o | output | 1 | New value valid |
| nia_valid_o | output | 1 | Next-instruction address must be reloaded |

## Verification
The assertions assume that every input is stable and known at each rising edge. They also assume that `op_i` carries one of the four listed codes, and they treat the reserved code as an idle cycle. The stimulus changes inputs only on falling edges. It draws codes over the full two-bit range, so the reserved code appears as often as the others. About half the move-to-register cases force the exact pattern of the 29..31 condition, so both sides of that rule are reached.

// File: rtl/msr_upd_pkg.sv
package msr_upd_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_MTMSR = 2'b01,
    OP_RFI   = 2'b10,
    OP_RSVD  = 2'b11
  } msr_op_e;

  // MSB-0 field positions
  localparam int B_TS_HI = 29;
  localparam int B_TS_LO = 31;
  localparam int B_EE    = 48;
  localparam int B_PR    = 49;
  localparam int B_FP    = 50;
  localparam int B_FE0   = 52;
  localparam int B_TE_HI = 53;
  localparam int B_TE_LO = 54;
  localparam int B_UND   = 56;
  localparam int B_IR    = 58;
  localparam int B_DR    = 59;
  localparam int B_PMM   = 61;
  localparam int B_RI    = 62;

  function automatic int le(input int b);
    return XLEN - 1 - b;
  endfunction

  // mask for MSB-0 span a..b inclusive
  function automatic logic [XLEN-1:0] span(input int a, input int b);
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = a; i <= b; i++) m[le(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] TRAP_CLR_MASK =
      span(B_IR, B_IR) | span(B_DR, B_DR) | span(B_FE0, B_FE0) |
      span(B_FP, B_FP) | span(B_PMM, B_PMM) | span(B_UND, B_UND) |
      span(B_TE_HI, B_TE_LO);

  // full-update copy region, merged bits included
  localparam logic [XLEN-1:0] MT_COPY_MASK = span(32, 50) | span(52, 62);
  localparam logic [XLEN-1:0] TS_MASK      = span(B_TS_HI, B_TS_LO);
  localparam logic [XLEN-1:0] MT_PART_MASK = span(B_EE, B_EE) | span(B_RI, B_RI);
endpackage

// File: rtl/msr_trap_clear.sv
module msr_trap_clear
  import msr_upd_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] msr_o
);
  // same pattern for every trap vector
  assign msr_o = msr_i & ~TRAP_CLR_MASK;
endmodule

// File: rtl/msr_pr_merge.sv
module msr_pr_merge
  import msr_upd_pkg::*;
(
  input  logic [XLEN-1:0] val_i,
  output logic [XLEN-1:0] val_o
);
  localparam int NMERGE = 3;
  localparam int MERGE_BITS [NMERGE] = '{B_EE, B_IR, B_DR};

  logic pr;
  assign pr = val_i[le(B_PR)];

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NMERGE; k++)
        if (le(MERGE_BITS[k]) == b) hit = 1'b1;
    end
    assign val_o[b] = val_i[b] | (hit & pr);
  end
endmodule

// File: rtl/msr_mtmsr_path.sv
module msr_mtmsr_path
  import msr_upd_pkg::*;
(
  input  logic            l_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] srr_i,
  output logic [XLEN-1:0] msr_o
);
  localparam int TS_H = XLEN - 1 - B_TS_HI;
  localparam int TS_L = XLEN - 1 - B_TS_LO;

  logic [XLEN-1:0] src_m;
  logic            keep_ts;
  logic [XLEN-1:0] full_v, ts_mask;

  msr_pr_merge u_merge (.val_i(src_i), .val_o(src_m));

  assign keep_ts = (msr_i[TS_H:TS_L] != 3'b010) || (srr_i[TS_H:TS_L] != 3'b000);
  assign ts_mask = keep_ts ? '0 : TS_MASK;
  assign full_v  = (msr_i & ~(MT_COPY_MASK | ts_mask)) |
                   (src_m & MT_COPY_MASK) | (src_i & ts_mask);

  always_comb begin
    if (l_i) msr_o = (msr_i & ~MT_PART_MASK) | (src_i & MT_PART_MASK);
    else     msr_o = full_v;
  end
endmodule

// File: rtl/msr_update_unit.sv
module msr_update_unit
  import msr_upd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      op_i,
  input  logic            l_i,
  input  logic            trap_i,
  input  logic [63:0]     msr_i,
  input  logic [63:0]     src_i,
  input  logic [63:0]     srr_i,
  output logic [63:0]     msr_o,
  output logic            msr_valid_o,
  output logic            nia_valid_o
);
  msr_op_e         op;
  logic [XLEN-1:0] trap_v, mt_v, rfi_v, nxt;
  logic            upd, nia;

  assign op = msr_op_e'(op_i);

  msr_trap_clear u_trap  (.msr_i(msr_i), .msr_o(trap_v));
  msr_mtmsr_path u_mtmsr (.l_i(l_i), .msr_i(msr_i), .src_i(src_i),
                          .srr_i(srr_i), .msr_o(mt_v));
  msr_pr_merge   u_rfi   (.val_i(srr_i), .val_o(rfi_v));

  always_comb begin
    nxt = msr_o;
    upd = 1'b0;
    nia = 1'b0;
    if (trap_i) begin
      nxt = trap_v; upd = 1'b1; nia = 1'b1;
    end else begin
      unique case (op)
        OP_MTMSR: begin nxt = mt_v;  upd = 1'b1; end
        OP_RFI:   begin nxt = rfi_v; upd = 1'b1; nia = 1'b1; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_o       <= '0;
      msr_valid_o <= 1'b0;
      nia_valid_o <= 1'b0;
    end else begin
      msr_o       <= nxt;
      msr_valid_o <= upd;
      nia_valid_o <= nia;
    end
  end

  p_trap_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> msr_valid_o && nia_valid_o &&
               ((msr_o & TRAP_CLR_MASK) == '0) &&
               ((msr_o & ~TRAP_CLR_MASK) == ($past(msr_i) & ~TRAP_CLR_MASK)));

  p_pr_merge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_i && op_i == 2'b01 && !l_i && src_i[le(B_PR)]) |=>
      msr_o[le(B_EE)] && msr_o[le(B_IR)] && msr_o[le(B_DR)]);

  p_l1_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_i && op_i == 2'b01 && l_i) |=>
      msr_valid_o && !nia_valid_o &&
      ((msr_o & ~MT_PART_MASK) == ($past(msr_i) & ~MT_PART_MASK)));

  p_rfi_valids_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_i && op_i == 2'b10) |=> msr_valid_o && nia_valid_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_i && (op_i == 2'b00 || op_i == 2'b11)) |=>
      !msr_valid_o && !nia_valid_o && $stable(msr_o));
endmodule

// File: tb/msr_update_unit_test.sv
module msr_update_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        l_i = 1'b0;
  logic        trap_i = 1'b0;
  logic [63:0] msr_i = '0, src_i = '0, srr_i = '0;
  logic [63:0] msr_o;
  logic        msr_valid_o, nia_valid_o;

  int checks = 0, fails = 0;
  logic [63:0] exp_msr = '0;
  bit done = 0;

  always #2 clk = ~clk;

  msr_update_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .l_i(l_i), .trap_i(trap_i),
    .msr_i(msr_i), .src_i(src_i), .srr_i(srr_i),
    .msr_o(msr_o), .msr_valid_o(msr_valid_o), .nia_valid_o(nia_valid_o));

  function automatic bit gb(logic [63:0] v, int b); return v[63-b]; endfunction

  // reference model written per MSB-0 bit
  function automatic logic [63:0] ref_msr(logic [1:0] op, bit l, bit tr,
      logic [63:0] m, logic [63:0] s, logic [63:0] r, logic [63:0] prev);
    logic [63:0] o;
    bit keep;
    o = prev;
    if (tr) begin
      for (int b = 0; b < 64; b++) begin
        bit clr;
        clr = (b == 58 || b == 59 || b == 52 || b == 50 || b == 61 ||
               b == 56 || b == 53 || b == 54);
        o[63-b] = clr ? 1'b0 : gb(m, b);
      end
    end else if (op == 2'b01 && l) begin
      for (int b = 0; b < 64; b++)
        o[63-b] = (b == 48 || b == 62) ? gb(s, b) : gb(m, b);
    end else if (op == 2'b01) begin
      keep = !(gb(m,29) == 0 && gb(m,30) == 1 && gb(m,31) == 0 &&
               gb(r,29) == 0 && gb(r,30) == 0 && gb(r,31) == 0);
      for (int b = 0; b < 64; b++) begin
        if (b == 48 || b == 58 || b == 59) o[63-b] = gb(s, b) | gb(s, 49);
        else if ((b >= 32 && b <= 47) || b == 49 || b == 50 ||
                 (b >= 52 && b <= 57) || (b >= 60 && b <= 62)) o[63-b] = gb(s, b);
        else if (b >= 29 && b <= 31) o[63-b] = keep ? gb(m, b) : gb(s, b);
        else o[63-b] = gb(m, b);
      end
    end else if (op == 2'b10) begin
      for (int b = 0; b < 64; b++)
        o[63-b] = (b == 48 || b == 58 || b == 59) ? (gb(r, b) | gb(r, 49)) : gb(r, b);
    end
    return o;
  endfunction

  task automatic check(string req, logic [63:0] am, logic [63:0] em,
                       bit av, bit ev, bit an, bit en);
    checks++;
    if (am !== em || av !== ev || an !== en) begin
      fails++;
      $display("FAIL %s: msr=%h v=%b nia=%b expected msr=%h v=%b nia=%b",
               req, am, av, an, em, ev, en);
    end
  endtask

  task automatic apply(string req, logic [1:0] op, bit l, bit tr,
                       logic [63:0] m, logic [63:0] s, logic [63:0] r);
    bit ev, en;
    @(negedge clk);
    op_i = op; l_i = l; trap_i = tr; msr_i = m; src_i = s; srr_i = r;
    exp_msr = ref_msr(op, l, tr, m, s, r, exp_msr);
    ev = tr || op == 2'b01 || op == 2'b10;
    en = tr || op == 2'b10;
    @(posedge clk); #1;
    check(req, msr_o, exp_msr, msr_valid_o, ev, nia_valid_o, en);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: expired expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset", msr_o, 64'h0, msr_valid_o, 1'b0, nia_valid_o, 1'b0);
    rst_ni = 1'b1;

    // R2 R3: trap clears fields, overrides op codes
    apply("R2 trap all ones", 2'b00, 0, 1, '1, '0, '0);
    apply("R3 trap beats mtmsr", 2'b01, 0, 1, 64'h0123_4567_89ab_cdef, '1, '1);
    apply("R3 trap beats rfi", 2'b10, 1, 1, '1, '0, '1);
    // R9 idle and reserved hold
    apply("R9 idle hold", 2'b00, 0, 0, '0, '1, '1);
    apply("R9 reserved hold", 2'b11, 1, 0, '0, '1, '1);
    // R4 merge driven only by PR bit
    apply("R4 pr merge", 2'b01, 0, 0, '0, 64'h1 << (63-49), '0);
    apply("R5 copy ranges", 2'b01, 0, 0, '1, '0, '1);
    // R6 both sides of the condition
    apply("R6 ts copy", 2'b01, 0, 0, 64'h0000_0002_0000_0000, '1, '0);
    apply("R6 ts keep msr", 2'b01, 0, 0, 64'h0000_0003_0000_0000, '0, '0);
    apply("R6 ts keep srr", 2'b01, 0, 0, 64'h0000_0002_0000_0000, '1, 64'h0000_0001_0000_0000);
    // R7 partial update
    apply("R7 partial ones", 2'b01, 1, 0, '0, '1, '0);
    apply("R7 partial zeros", 2'b01, 1, 0, '1, '0, '1);
    // R8 rfi
    apply("R8 rfi merge", 2'b10, 0, 0, '1, '1, 64'h1 << (63-49));
    apply("R8 rfi plain", 2'b10, 0, 0, '0, '0, 64'hfedc_ba98_7654_3210);

    // R10: random mix, one-cycle latency each vector
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] m, s, r;
      logic [1:0] op;
      bit l, tr;
      m  = {$urandom, $urandom};
      s  = {$urandom, $urandom};
      r  = {$urandom, $urandom};
      op = 2'($urandom);
      l  = 1'($urandom);
      tr = ($urandom % 8) == 0;
      if ($urandom % 2) begin
        m[34:32] = 3'b010;
        r[34:32] = 3'b000;
      end
      apply("R10 random", op, l, tr, m, s, r);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule